// File: doc/BRIEF.md
# Quadrature Position Counter with Cascade Output

This block turns the two phase-shifted channel signals of an incremental encoder into a 32-bit signed-agnostic position count. Both channels pass through a two-flop synchronizer. A 4x decoder then gives one count step for every legal edge on either channel, and the direction follows which channel leads. Whenever the count wraps in either direction, the block raises a one-cycle cascade pulse and drives a direction line, so an external counter can extend the position beyond 32 bits.

The host reads the position one byte at a time over an 8-bit bus. A holding register copies the count on every falling clock edge. When the host selects the most significant byte with output enable low, that register freezes at the falling edge. It stays frozen until the least significant byte has been read and output enable has been raised again. All four bytes of one read therefore come from the same instant, even while the encoder keeps moving.

Top module: `quad_pos_counter`

## Requirements
- R1: With the synchronized channels encoded as {chan_a, chan_b}, the forward sequence 00, 10, 11, 01, 00 (channel A leading) adds one to the count per transition, and the reverse sequence subtracts one per transition.
- R2: The count is 32 bits wide. Adding one to FFFFFFFFh gives 00000000h, and subtracting one from 00000000h gives FFFFFFFFh.
- R3: wrap_pulse is high for exactly one clock cycle, in the cycle that the wrapped count first appears, and only after a wrap.
- R4: wrap_up gives the direction of the most recent count step: 1 for up, 0 for down. It is valid while wrap_pulse is high.
- R5: While the holding register is not frozen, it follows the count. With oe_n low, byte_sel value k puts bits 8k+7..8k of the holding register on data_out (k = 3 is the most significant byte).
- R6: byte_sel = 3 together with oe_n low freezes the holding register at the next falling clock edge. Later count changes do not reach data_out until the register is released.
- R7: The freeze ends only at the first falling edge with oe_n high after byte 0 has been read (byte_sel = 0, oe_n low) while frozen. Raising oe_n without reading byte 0 keeps the old snapshot.
- R8: A change of both synchronized channels in one step is illegal and leaves the count unchanged.
- R9: While oe_n is high, data_out is 00h.
- R10: A synchronous active-high reset clears the count, the holding register, the freeze state and wrap_pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the count updates on rising edges, the holding register on falling edges |
| rst | input | 1 | Synchronous active-high reset |
| chan_a | input | 1 | Encoder channel A (asynchronous) |
| chan_b | input | 1 | Encoder channel B (asynchronous) |
| byte_sel | input | 2 | Byte index to read; 3 selects the most significant byte |
| oe_n | input | 1 | Active-low output enable for the read bus |
| data_out | output | 8 | Selected byte of the holding register, or 00h when disabled |
| wrap_pulse | output | 1 | One-cycle pulse on every count wrap |
| wrap_up | output | 1 | Direction of the latest count step (1 = up) |

## Verification
Two functions can fall in the same cycle: a count step, and the falling edge that freezes the holding register. The bench starts a read with the high byte and keeps stepping the encoder while the remaining bytes are fetched. Every byte of that read must match the count from before the freeze. A second read after release must then show the moved count. A partial read that skips byte 0 checks that a rising oe_n alone does not release the register, and table vectors that step through 00000000h in both directions pair each wrap with its cascade pulse and direction.

// File: rtl/qcnt_pkg.sv
package qcnt_pkg;
    localparam int CNT_W_DEF = 32;
    localparam int BUS_W_DEF = 8;
    localparam int SYNC_DEF  = 2;

    typedef logic [1:0] quad_t;

    // Next phase in the forward (channel A leading) sequence 00,10,11,01
    function automatic quad_t quad_fwd(input quad_t s);
        case (s)
            2'b00:   quad_fwd = 2'b10;
            2'b10:   quad_fwd = 2'b11;
            2'b11:   quad_fwd = 2'b01;
            default: quad_fwd = 2'b00;
        endcase
    endfunction
endpackage

// File: rtl/qcnt_sync.sv
module qcnt_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < STAGES; i++) begin
            if (rst) stg_q[i] <= '0;
            else     stg_q[i] <= stg_d[i];
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/qcnt_decode.sv
module qcnt_decode
    import qcnt_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  quad_t cur,
    output logic  step,
    output logic  up
);
    quad_t prev_d, prev_q;

    always_comb begin
        prev_d = cur;
        up     = (cur == quad_fwd(prev_q));
        step   = up || (prev_q == quad_fwd(cur));
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= prev_d;
    end

    // R8
    single_bit_step_chk: assert property (@(posedge clk) disable iff (rst)
        step |-> ($countones(prev_q ^ cur) == 1));
endmodule

// File: rtl/qcnt_core.sv
module qcnt_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             up,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap,
    output logic             dir
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             wrap;
        logic             dir;
    } core_t;

    core_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.wrap = 1'b0;
        if (step) begin
            r_d.dir = up;
            if (up) begin
                r_d.cnt  = r_q.cnt + CNT_W'(1);
                r_d.wrap = &r_q.cnt;
            end else begin
                r_d.cnt  = r_q.cnt - CNT_W'(1);
                r_d.wrap = ~|r_q.cnt;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign cnt  = r_q.cnt;
    assign wrap = r_q.wrap;
    assign dir  = r_q.dir;

    // R3
    wrap_state_chk: assert property (@(posedge clk) disable iff (rst)
        r_q.wrap |-> (r_q.dir ? (r_q.cnt == '0) : (r_q.cnt == '1)));
    // R2
    unit_step_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (r_q.cnt == $past(r_q.cnt) ||
                  r_q.cnt == $past(r_q.cnt) + CNT_W'(1) ||
                  r_q.cnt == $past(r_q.cnt) - CNT_W'(1)));
endmodule

// File: rtl/qcnt_hold.sv
module qcnt_hold #(
    parameter int CNT_W = 32,
    parameter int BUS_W = 8,
    localparam int NBYTES = CNT_W / BUS_W,
    localparam int SEL_W  = $clog2(NBYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt,
    input  logic [SEL_W-1:0] sel,
    input  logic             oe_n,
    output logic [BUS_W-1:0] data
);
    typedef struct packed {
        logic [CNT_W-1:0] snap;
        logic             frz;
        logic             low_done;
    } hold_t;

    hold_t h_d, h_q;
    logic start, release_now;
    logic [BUS_W-1:0] bytes [NBYTES];

    always_comb begin
        start       = !oe_n && (sel == SEL_W'(NBYTES - 1));
        release_now = h_q.frz && h_q.low_done && oe_n;
        h_d         = h_q;
        if (h_q.frz) begin
            if (!oe_n && sel == '0) h_d.low_done = 1'b1;
            if (release_now) begin
                h_d.frz      = 1'b0;
                h_d.low_done = 1'b0;
            end
        end
        if (!h_d.frz) begin
            if (start) h_d.frz  = 1'b1;
            else       h_d.snap = cnt;
        end
    end

    always_ff @(negedge clk) begin
        if (rst) h_q <= '0;
        else     h_q <= h_d;
    end

    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        assign bytes[g] = h_q.snap[g*BUS_W +: BUS_W];
    end

    assign data = oe_n ? '0 : bytes[sel];

    // R6
    freeze_origin_chk: assert property (@(negedge clk) disable iff (rst)
        $rose(h_q.frz) |-> $past(!oe_n && sel == SEL_W'(NBYTES - 1)));
    // R7
    snapshot_hold_chk: assert property (@(negedge clk) disable iff (rst)
        (h_q.frz && $past(h_q.frz)) |-> $stable(h_q.snap));
endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter
    import qcnt_pkg::*;
#(
    parameter int CNT_W       = CNT_W_DEF,
    parameter int BUS_W       = BUS_W_DEF,
    parameter int SYNC_STAGES = SYNC_DEF,
    localparam int NBYTES = CNT_W / BUS_W,
    localparam int SEL_W  = $clog2(NBYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             chan_a,
    input  logic             chan_b,
    input  logic [SEL_W-1:0] byte_sel,
    input  logic             oe_n,
    output logic [BUS_W-1:0] data_out,
    output logic             wrap_pulse,
    output logic             wrap_up
);
    quad_t            chan_s;
    logic             step, up;
    logic [CNT_W-1:0] cnt;

    qcnt_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .din({chan_a, chan_b}), .dout(chan_s)
    );

    qcnt_decode u_dec (
        .clk(clk), .rst(rst), .cur(chan_s), .step(step), .up(up)
    );

    qcnt_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst(rst), .step(step), .up(up),
        .cnt(cnt), .wrap(wrap_pulse), .dir(wrap_up)
    );

    qcnt_hold #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_hold (
        .clk(clk), .rst(rst), .cnt(cnt), .sel(byte_sel), .oe_n(oe_n),
        .data(data_out)
    );

    // R9
    idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> (data_out == '0));
endmodule

// File: tb/quad_pos_counter_test.sv
`timescale 1ns/1ps
module quad_pos_counter_test;
    logic       clk = 0;
    logic       rst = 1;
    logic       chan_a = 0, chan_b = 0;
    logic [1:0] byte_sel = 0;
    logic       oe_n = 1;
    logic [7:0] data_out;
    logic       wrap_pulse, wrap_up;

    int checks = 0, fails = 0;
    int wraps = 0;
    logic last_up = 0;
    int phase = 0;
    logic [31:0] w;

    localparam int          NV = 8;
    localparam int          VSTEP  [NV] = '{5, -3, -4, 3, -1, -1, 1, 9};
    localparam logic [31:0] VEXP   [NV] = '{32'd5, 32'd2, 32'hFFFF_FFFE, 32'd1,
                                            32'd0, 32'hFFFF_FFFF, 32'd0, 32'd9};
    localparam int          VWRAP  [NV] = '{0, 0, 1, 1, 0, 1, 1, 0};
    localparam logic        VUP    [NV] = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1};

    quad_pos_counter uut (
        .clk(clk), .rst(rst), .chan_a(chan_a), .chan_b(chan_b),
        .byte_sel(byte_sel), .oe_n(oe_n), .data_out(data_out),
        .wrap_pulse(wrap_pulse), .wrap_up(wrap_up)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) if (!rst && wrap_pulse) begin
        wraps++;
        last_up = wrap_up;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive_phase();
        case (phase & 3)
            0: {chan_a, chan_b} = 2'b00;
            1: {chan_a, chan_b} = 2'b10;
            2: {chan_a, chan_b} = 2'b11;
            default: {chan_a, chan_b} = 2'b01;
        endcase
    endtask

    task automatic move(input int n);
        for (int i = 0; i < (n < 0 ? -n : n); i++) begin
            @(posedge clk); #1;
            phase = (n > 0) ? phase + 1 : phase + 3;
            drive_phase();
            @(posedge clk);
        end
        repeat (6) @(posedge clk);
    endtask

    task automatic read_byte(input logic [1:0] k, output logic [7:0] b);
        @(posedge clk); #1 byte_sel = k; oe_n = 0;
        @(negedge clk); #1 b = data_out;
    endtask

    task automatic end_read();
        @(posedge clk); #1 oe_n = 1;
        repeat (2) @(posedge clk);
    endtask

    task automatic read_word(output logic [31:0] v);
        logic [7:0] b;
        for (int k = 3; k >= 0; k--) begin
            read_byte(2'(k), b);
            v[k*8 +: 8] = b;
        end
        end_read();
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        repeat (2) @(posedge clk);
        // R10 reset state
        chk("R10 wrap_pulse at reset", {31'd0, wrap_pulse}, 32'd0);
        read_word(w);
        chk("R10 count at reset", w, 32'd0);

        // Table: R1 R2 R3 R4 R5
        for (int v = 0; v < NV; v++) begin
            wraps = 0;
            move(VSTEP[v]);
            read_word(w);
            chk("R1/R2/R5 count", w, VEXP[v]);
            chk("R3 wrap pulses", wraps, VWRAP[v]);
            if (VWRAP[v] != 0) chk("R4 wrap direction", {31'd0, last_up}, {31'd0, VUP[v]});
        end

        // R6: count moves during a read, snapshot must hold
        begin
            logic [7:0] b;
            read_byte(2'd3, b);
            chk("R6 byte3", {24'd0, b}, 32'd0);
            move(4);
            read_byte(2'd2, b); chk("R6 byte2", {24'd0, b}, 32'd0);
            read_byte(2'd1, b); chk("R6 byte1", {24'd0, b}, 32'd0);
            read_byte(2'd0, b); chk("R6 byte0 frozen", {24'd0, b}, 32'd9);
            end_read();
            read_word(w);
            chk("R6 after release", w, 32'd13);

            // R7: partial read (no byte 0) must not release
            read_byte(2'd3, b);
            end_read();
            move(2);
            read_byte(2'd2, b);
            read_byte(2'd0, b);
            chk("R7 still frozen", {24'd0, b}, 32'd13);
            end_read();
            read_word(w);
            chk("R7 released", w, 32'd15);
        end

        // R8: both channels change at once
        @(posedge clk); #1 {chan_a, chan_b} = ~{chan_a, chan_b};
        repeat (8) @(posedge clk);
        #1 drive_phase();
        repeat (8) @(posedge clk);
        read_word(w);
        chk("R8 illegal jump ignored", w, 32'd15);

        // R9: bus idle at zero when disabled
        @(posedge clk); #1 byte_sel = 0; oe_n = 1;
        @(negedge clk); #1;
        chk("R9 idle bus", {24'd0, data_out}, 32'd0);

        // R10: reset clears the count
        @(posedge clk); #1 rst = 1;
        repeat (2) @(posedge clk);
        #1 rst = 0;
        repeat (2) @(posedge clk);
        read_word(w);
        chk("R10 count after reset", w, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule